// File: doc/BRIEF.md
# Two-Wire Data/Strobe Serial Receiver

This block takes a serial stream carried on two wires, a data line and a companion strobe line, and turns it into parallel words in the local clock domain. No clock wire is needed: the transmitter changes exactly one of the two lines per bit. It flips data when the bit value changes and flips strobe when the value repeats. The exclusive-OR of the two lines therefore toggles once per bit and serves as the receive clock.

Bits are captured on both edges of that recovered clock. Even-numbered bits are taken on its rising edge. Odd-numbered bits are taken on its falling edge, and that falling edge also drives the whole assembly path. Each finished word is parked in a holding register and announced to the local domain by flipping a flag. The flag crosses through a two-flop synchroniser, and the local side then presents the word together with a one-cycle valid pulse.

A watchdog in the local domain watches line activity. After a long silence it raises a link-down flag and briefly clears the receive-side assembly state, so a half-received word is thrown away and the next bit begins a fresh word. The block assumes that the recovered clock rests low whenever the line is idle, so word widths are even. It also assumes that one bit lasts several local clock cycles.

Top module: `ds_link_rx`

## Requirements
- R1: The receive clock is the exclusive-OR of the data and strobe lines. A bit is taken on every transition of that clock, both rising and falling. A bit that repeats its predecessor, which is carried by a strobe transition, decodes the same way as a bit carried by a data transition.
- R2: Bits fill a word in arrival order. The first bit of a word appears on `word_o[0]` and bit k appears on `word_o[k]`.
- R3: After every WORD_W received bits, `word_valid_o` is high for exactly one local cycle. Take the first local rising edge after the line transition of the word's final bit; the pulse begins at the second local rising edge after that one. The pulse is never high on two consecutive cycles.
- R4: `word_o` changes only in a cycle where `word_valid_o` is high, and it holds the last delivered word otherwise.
- R5: While `rst_n` is low, `word_o` reads zero and `word_valid_o` and `link_down_o` read low. The first bit received after reset is bit 0 of a word, whatever bits arrived before the reset.
- R6: `link_down_o` rises when IDLE_LIMIT local rising edges pass without line activity. Activity is counted from the third local edge after a line transition, or from the last edge with reset held.
- R7: When `link_down_o` rises, any partly received word is discarded. The next bit received is bit 0 of a new word, and only complete words are ever delivered.
- R8: `link_down_o` falls at the third local rising edge after a line transition, and it falls only after line activity has been seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local system clock |
| rst_n | input | 1 | Active-low reset; synchronous in the local domain, also clears the receive-side flops |
| ds_data_i | input | 1 | Serial data line |
| ds_strobe_i | input | 1 | Strobe line, toggles when a bit repeats |
| word_o | output | WORD_W | Last delivered word, bit 0 received first |
| word_valid_o | output | 1 | One-cycle pulse marking a new word |
| link_down_o | output | 1 | High while the line has been silent for the idle limit |

## Verification
The bench builds the receiver with WORD_W = 6 and IDLE_LIMIT = 24. The narrow word means that runs of repeated bits, alternating bits and mixtures of the two are each covered by words that finish within a few dozen cycles. The short idle limit means that disconnects, discards of a partial word and recovery all fit into a run that is also long enough to carry many back-to-back words. Bits are spaced five local cycles apart, which keeps the synchroniser latency exact and allows the valid pulse and the link-down flag to be predicted to the cycle.

// File: rtl/ds_rx_pkg.sv
// Shared constants for the data/strobe receiver.
// Assumes: nothing beyond the language; holds defaults only.
package ds_rx_pkg;
    // Default word width, must be even and at least 4.
    localparam int DEF_WORD_W = 8;
    // Default number of silent local cycles before link-down.
    localparam int DEF_IDLE_LIMIT = 64;
    // Number of local flops used to bring a receive-side level across.
    localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/ds_rx_capture.sv
// Receive-side capture and assembly, clocked by the recovered clock.
// Even bits are caught on the rising edge, odd bits on the falling edge,
// and the falling edge drives the assembly shift path and word hand-off.
// Assumes: WORD_W even and >= 4; the recovered clock rests low when the
// line is idle; asm_rst_n clears assembly state, rst_n the hand-off state.
module ds_rx_capture #(
    parameter int WORD_W = ds_rx_pkg::DEF_WORD_W
) (
    input  logic              data_i,
    input  logic              strobe_i,
    input  logic              asm_rst_n,
    input  logic              rst_n,
    output logic [WORD_W-1:0] held_word_o,
    output logic              flag_o
);
    localparam int PAIRS = WORD_W / 2;
    localparam int PW    = (PAIRS > 1) ? $clog2(PAIRS) : 1;
    localparam logic [PW-1:0] LAST_PAIR = PW'(PAIRS - 1);

    logic              rclk;
    logic              even_q;
    logic [WORD_W-3:0] shreg;
    logic [PW-1:0]     pair_cnt;
    logic [WORD_W-1:0] assembled;
    logic              last_pair;

    // Recovered bit clock: toggles once per transmitted bit.
    assign rclk = data_i ^ strobe_i;

    // Newest pair on top, older bits slide toward bit 0.
    assign assembled = {data_i, even_q, shreg};
    assign last_pair = (pair_cnt == LAST_PAIR);

    // Even-bit capture on the rising edge of the recovered clock.
    always_ff @(posedge rclk or negedge asm_rst_n) begin
        if (!asm_rst_n) even_q <= 1'b0;
        else            even_q <= data_i;
    end

    // Odd-bit capture and pair shift on the falling edge.
    always_ff @(negedge rclk or negedge asm_rst_n) begin
        if (!asm_rst_n) begin
            shreg    <= '0;
            pair_cnt <= '0;
        end else begin
            shreg    <= assembled[WORD_W-1:2];
            pair_cnt <= last_pair ? '0 : pair_cnt + 1'b1;
        end
    end

    // Park a completed word and flip the flag for the local domain.
    always_ff @(negedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            held_word_o <= '0;
            flag_o      <= 1'b0;
        end else if (last_pair) begin
            held_word_o <= assembled;
            flag_o      <= ~flag_o;
        end
    end
endmodule

// File: rtl/ds_rx_handoff.sv
// Local-domain side of the word hand-off: synchronises the receive-side
// flag, turns each flip into a one-cycle valid pulse and latches the word.
// Assumes: the held word is stable for well over three local cycles
// after each flag flip (bits slower than the local clock).
module ds_rx_handoff #(
    parameter int WORD_W = ds_rx_pkg::DEF_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_i,
    input  logic [WORD_W-1:0] held_word_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o
);
    localparam int NS = ds_rx_pkg::SYNC_STAGES;

    logic [NS-1:0] sync_q;
    logic          seen_q;
    logic          flip;

    assign flip = sync_q[NS-1] ^ seen_q;

    // Two-flop synchroniser plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            seen_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[NS-2:0], flag_i};
            seen_q <= sync_q[NS-1];
        end
    end

    // Present the word with a single-cycle valid on each flag flip.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= flip;
            if (flip) word_o <= held_word_i;
        end
    end

    assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_word_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(word_o));
endmodule

// File: rtl/ds_rx_linkwatch.sv
// Line-activity watchdog in the local domain. Samples the recovered clock
// level, restarts a counter on every change, raises link-down after the
// idle limit and issues a one-cycle clear of the receive-side assembly.
// Assumes: IDLE_LIMIT >= 2; line changes are spaced over three local cycles.
module ds_rx_linkwatch #(
    parameter int IDLE_LIMIT = ds_rx_pkg::DEF_IDLE_LIMIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_i,
    input  logic strobe_i,
    output logic down_o,
    output logic clr_o
);
    localparam int CW = $clog2(IDLE_LIMIT);
    localparam logic [CW-1:0] LIM_M1 = CW'(IDLE_LIMIT - 1);

    logic [2:0]    lvl_q;
    logic          seen;
    logic [CW-1:0] idle_cnt;
    logic          at_limit;

    assign seen     = lvl_q[1] ^ lvl_q[2];
    assign at_limit = (idle_cnt == LIM_M1);

    // Bring the recovered clock level across and keep one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= {lvl_q[1:0], data_i ^ strobe_i};
    end

    // Count silent cycles, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)        idle_cnt <= '0;
        else if (seen)     idle_cnt <= '0;
        else if (!at_limit) idle_cnt <= idle_cnt + 1'b1;
    end

    // Link-down flag and the one-shot assembly clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            down_o <= 1'b0;
            clr_o  <= 1'b0;
        end else begin
            clr_o <= at_limit && !seen && !down_o;
            if (seen)          down_o <= 1'b0;
            else if (at_limit) down_o <= 1'b1;
        end
    end

    assert_down_clears_asm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(down_o) |-> clr_o);

    assert_clear_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |=> !clr_o);

    assert_down_needs_activity_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(down_o) |-> $past(seen));
endmodule

// File: rtl/ds_link_rx.sv
// Top of the data/strobe receiver: receive-side capture, local hand-off
// and line watchdog. The assembly path is cleared by reset or by the
// watchdog's one-shot clear; the hand-off flag only by reset.
// Assumes: WORD_W even and >= 4, line idle with data equal to strobe
// during reset, bit period several local cycles long.
module ds_link_rx #(
    parameter int WORD_W     = ds_rx_pkg::DEF_WORD_W,
    parameter int IDLE_LIMIT = ds_rx_pkg::DEF_IDLE_LIMIT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ds_data_i,
    input  logic              ds_strobe_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_valid_o,
    output logic              link_down_o
);
    logic              asm_clr;
    logic              asm_rst_n;
    logic [WORD_W-1:0] held_word;
    logic              flag;

    // Assembly state is dropped on reset or on a disconnect.
    assign asm_rst_n = rst_n & ~asm_clr;

    ds_rx_capture #(.WORD_W(WORD_W)) u_capture (
        .data_i      (ds_data_i),
        .strobe_i    (ds_strobe_i),
        .asm_rst_n   (asm_rst_n),
        .rst_n       (rst_n),
        .held_word_o (held_word),
        .flag_o      (flag)
    );

    ds_rx_handoff #(.WORD_W(WORD_W)) u_handoff (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_i      (flag),
        .held_word_i (held_word),
        .word_o      (word_o),
        .valid_o     (word_valid_o)
    );

    ds_rx_linkwatch #(.IDLE_LIMIT(IDLE_LIMIT)) u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_i   (ds_data_i),
        .strobe_i (ds_strobe_i),
        .down_o   (link_down_o),
        .clr_o    (asm_clr)
    );
endmodule

// File: tb/sim_ds_link_rx.sv
// Bench: drives the two-wire line by the one-line-per-bit rule and compares
// valid, word and link-down against a behavioural model on every clock.
module sim_ds_link_rx;
    localparam int W   = 6;
    localparam int LIM = 24;
    localparam int GAP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic d = 1'b0;
    logic s = 1'b0;
    logic [W-1:0] word_o;
    logic word_valid_o;
    logic link_down_o;

    always #5 clk = ~clk;

    ds_link_rx #(.WORD_W(W), .IDLE_LIMIT(LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .ds_data_i(d), .ds_strobe_i(s),
        .word_o(word_o), .word_valid_o(word_valid_o), .link_down_o(link_down_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cc = 0;
    int last_act = 0;
    int pend = -1;
    int bit_cnt = 0;
    bit checking = 1'b0;
    bit done = 1'b0;
    logic [W-1:0] cur_word = '0;
    logic [W-1:0] exp_word = '0;
    int due_q[$];
    logic [W-1:0] wq[$];

    always @(posedge clk) cc <= cc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cc, act, exp);
        end
    endtask

    // Reference model, compared once per cycle away from the active edge.
    always @(negedge clk) begin
        if (checking) begin
            bit exp_v;
            bit exp_d;
            exp_v = (due_q.size() > 0) && (due_q[0] == cc);
            chk(word_valid_o == exp_v, "R3 valid pulse", int'(word_valid_o), int'(exp_v));
            if (exp_v) begin
                exp_word = wq.pop_front();
                void'(due_q.pop_front());
                chk(word_o == exp_word, "R1 R2 R7 delivered word", int'(word_o), int'(exp_word));
            end else begin
                chk(word_o == exp_word, "R4 word held", int'(word_o), int'(exp_word));
            end
            if (pend >= 0 && cc >= pend + 3) begin
                last_act = pend + 3;
                pend = -1;
            end
            exp_d = (cc - last_act) >= LIM;
            chk(link_down_o == exp_d, "R6 R8 link down", int'(link_down_o), int'(exp_d));
        end
    end

    // One bit per GAP cycles: flip data on a change, strobe on a repeat.
    task automatic send_bit(input logic b);
        @(posedge clk);
        #2;
        if (b != d) d = b;
        else        s = ~s;
        pend = cc;
        cur_word[bit_cnt] = b;
        bit_cnt++;
        if (bit_cnt == W) begin
            due_q.push_back(cc + 3);
            wq.push_back(cur_word);
            bit_cnt = 0;
        end
        repeat (GAP - 1) @(posedge clk);
    endtask

    task automatic send_word(input logic [W-1:0] w);
        for (int i = 0; i < W; i++) send_bit(w[i]);
    endtask

    // Stay silent past the limit; the partial word is dropped (R7).
    task automatic go_quiet();
        repeat (LIM + 8) @(posedge clk);
        bit_cnt = 0;
    endtask

    task automatic do_reset();
        checking = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        due_q.delete();
        wq.delete();
        bit_cnt = 0;
        exp_word = '0;
        pend = -1;
        // R5: reset state at the ports.
        chk(word_o == '0, "R5 reset word", int'(word_o), 0);
        chk(word_valid_o == 1'b0, "R5 reset valid", int'(word_valid_o), 0);
        chk(link_down_o == 1'b0, "R5 reset link down", int'(link_down_o), 0);
        last_act = cc;
        rst_n = 1'b1;
        checking = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] lf;
        do_reset();
        // R6: silence from reset raises link-down; first bit then starts a word (R5).
        repeat (LIM + 6) @(posedge clk);
        // R1: repeats carried by strobe, changes by data.
        send_word(6'b000000);
        send_word(6'b111111);
        send_word(6'b101010);
        send_word(6'b010101);
        // R2: asymmetric patterns pin the bit order.
        send_word(6'b000001);
        send_word(6'b100000);
        send_word(6'b110011);
        send_word(6'b001110);
        // R7: partial words of two and four bits are discarded.
        send_bit(1'b1);
        send_bit(1'b1);
        go_quiet();
        send_word(6'b011001);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(1'b1);
        send_bit(1'b0);
        go_quiet();
        send_word(6'b100111);
        // R5: reset mid-word; next bit is bit 0.
        send_bit(1'b1);
        send_bit(1'b0);
        do_reset();
        send_word(6'b111000);
        // R1 R3: back-to-back pseudo-random words.
        lf = 6'b101101;
        for (int k = 0; k < 12; k++) begin
            lf = {lf[4:0], lf[5] ^ lf[4]};
            send_word(lf);
        end
        // R6 R8: final silence and return of activity.
        go_quiet();
        send_word(6'b010011);
        repeat (10) @(posedge clk);
        chk(due_q.size() == 0, "R3 all words delivered", due_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule